// File: doc/BRIEF.md
# Even-Step Up/Down Counter

This block steps a 4-bit value through the even numbers 0, 2, 4 and 6. A direction input picks ascending or descending order, and the value wraps at both ends. The state moves only on a slow step tick. A built-in prescaler makes that tick from the system clock, at STEP_HZ steps per second (two by default, so steps are half a second apart).

The block takes an asynchronous active-low reset. Reset is applied at once and released through a synchroniser, and it clears both the state and the prescaler. The counter can drive a display or a set of indicator lamps directly. A testbench lowers CLK_HZ so that a step lasts a few clock cycles.

Top module: `even_step_counter`

## Requirements
- R1: While rst_n is low, count_val is 0, and it goes to 0 as soon as rst_n falls, without waiting for a clock edge.
- R2: With count_up high at each step, count_val advances 0 → 2 → 4 → 6 → 0 and repeats.
- R3: With count_up low at each step, count_val descends 6 → 4 → 2 → 0 → 6 and repeats.
- R4: Consecutive changes of count_val are exactly CLK_HZ/STEP_HZ clock cycles apart.
- R5: After rst_n rises, the first step occurs on the (CLK_HZ/STEP_HZ + 2)-th rising clock edge. The extra two edges are the reset synchroniser, and the prescaler starts from zero.
- R6: count_up is sampled only on the clock edge that carries a step. A change of count_up that is undone before that edge has no effect on the sequence.
- R7: count_val is always even and never above 6. Bit 0 and bit 3 are always 0, and bits 2:1 hold the 2-bit step state.
- R8: Between step edges, count_val holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| count_up | input | 1 | 1 = ascending even sequence, 0 = descending |
| count_val | output | 4 | Current even count value (0, 2, 4 or 6) |

## Verification
A corrupt step state appears at the output on the next step: either the value is odd or above 6, or it is not the even neighbour in the chosen direction. A prescaler fault appears at the first change after it, as a gap between changes that differs from the step interval. A synchroniser fault shifts the first step after reset by one or more cycles. Every fault therefore shows within one step interval, and the first step after reset also exposes the release path.

// File: rtl/esc_pkg.sv
package esc_pkg;
  // 2-bit step state; output value is state * 2
  localparam int STEP_W = 2;
  localparam int OUT_W  = 4;
  typedef logic [STEP_W-1:0] step_t;

  function automatic step_t step_next(step_t cur, logic up);
    step_t nxt;
    if (up) nxt = cur + step_t'(1);
    else    nxt = cur - step_t'(1);
    return nxt;
  endfunction

  function automatic logic [OUT_W-1:0] step_to_val(step_t s);
    return {1'b0, s, 1'b0};
  endfunction
endpackage

// File: rtl/esc_reset_sync.sv
module esc_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sr_q;
  logic [STAGES-1:0] sr_d;

  always_comb begin
    sr_d = {sr_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

  assign rst_sync_n = sr_q[STAGES-1];
endmodule

// File: rtl/esc_prescaler.sv
module esc_prescaler #(
  parameter int DIV = 50_000_000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          wrap;

  always_comb begin
    wrap  = (cnt_q == LAST);
    cnt_d = wrap ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick = wrap;
endmodule

// File: rtl/esc_step_fsm.sv
module esc_step_fsm
  import esc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_en,
  input  logic             count_up,
  output logic [OUT_W-1:0] value
);
  step_t state_q;
  step_t state_d;

  always_comb begin
    state_d = state_q;
    if (step_en) state_d = step_next(state_q, count_up);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= '0;
    else        state_q <= state_d;
  end

  assign value = step_to_val(state_q);
endmodule

// File: rtl/even_step_counter.sv
module even_step_counter #(
  parameter int CLK_HZ      = 100_000_000,
  parameter int STEP_HZ     = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       count_up,
  output logic [3:0] count_val
);
  localparam int DIV = CLK_HZ / STEP_HZ;

  logic rst_sync_n;
  logic step_tick;
  logic fsm_rst_n;

  esc_reset_sync #(.STAGES(SYNC_STAGES)) u_rsync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  esc_prescaler #(.DIV(DIV)) u_presc (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .tick  (step_tick)
  );

  // Raw reset forces the output to zero at once; release follows the synchroniser
  assign fsm_rst_n = rst_sync_n & rst_n;

  esc_step_fsm u_fsm (
    .clk      (clk),
    .rst_n    (fsm_rst_n),
    .step_en  (step_tick),
    .count_up (count_up),
    .value    (count_val)
  );
endmodule

// File: rtl/esc_checker.sv
module esc_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       count_up,
  input logic       tick,
  input logic       rst_sync_n,
  input logic [3:0] count_val
);
  // R7
  even_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count_val[0] == 1'b0) && (count_val[3] == 1'b0));

  // R2
  up_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && count_up && rst_sync_n) |=>
      (count_val == (($past(count_val) + 4'd2) & 4'd6)));

  // R3
  down_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !count_up && rst_sync_n) |=>
      (count_val == (($past(count_val) - 4'd2) & 4'd6)));

  // R8
  hold_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(count_val));

  // R5
  no_tick_in_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_sync_n |-> !tick);
endmodule

bind even_step_counter esc_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .count_up   (count_up),
  .tick       (step_tick),
  .rst_sync_n (rst_sync_n),
  .count_val  (count_val)
);

// File: tb/even_step_counter_test.sv
module even_step_counter_test;
  localparam int CLK_PERIOD = 10;
  localparam int T_CLK_HZ   = 10;
  localparam int T_STEP_HZ  = 2;
  localparam int DIV        = T_CLK_HZ / T_STEP_HZ;
  localparam int SYNC       = 2;

  logic       clk;
  logic       rst_n;
  logic       count_up;
  logic [3:0] count_val;

  int checks = 0;
  int errors = 0;
  int exp_q[$];
  int model_v = 0;
  int steps_seen = 0;
  int gap = 0;
  bit first = 1'b1;
  int prev_v = 0;
  bit done = 1'b0;

  even_step_counter #(.CLK_HZ(T_CLK_HZ), .STEP_HZ(T_STEP_HZ), .SYNC_STAGES(SYNC)) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .count_up  (count_up),
    .count_val (count_val)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard on every output change
  always @(negedge clk) begin
    if (!rst_n) begin
      gap = 0; first = 1'b1; prev_v = 0;
    end else begin
      gap++;
      if (int'(count_val) != prev_v) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R8 unexpected change", int'(count_val), prev_v);
        end else begin
          int e;
          e = exp_q.pop_front();
          check(int'(count_val) == e, count_up ? "R2 sequence" : "R3 sequence",
                int'(count_val), e);
        end
        check(count_val[0] == 1'b0 && count_val[3] == 1'b0, "R7 even range",
              int'(count_val), int'(count_val) & 6);
        if (first) check(gap == DIV + SYNC, "R5 first step delay", gap, DIV + SYNC);
        else       check(gap == DIV, "R4 step interval", gap, DIV);
        gap = 0; first = 1'b0; prev_v = int'(count_val); steps_seen++;
      end
    end
  end

  task automatic run_steps(input logic dir, input int n);
    int target;
    count_up = dir;
    target = steps_seen + n;
    for (int i = 0; i < n; i++) begin
      model_v = dir ? (model_v + 2) % 8 : (model_v + 6) % 8;
      exp_q.push_back(model_v);
    end
    wait (steps_seen >= target);
    #1;
  endtask

  task automatic apply_reset(input logic dir);
    @(negedge clk); #1;
    rst_n = 1'b0;
    #2;
    check(count_val == 4'd0, "R1 immediate reset", int'(count_val), 0);
    repeat (3) @(negedge clk);
    #1;
    check(count_val == 4'd0, "R1 held in reset", int'(count_val), 0);
    exp_q.delete();
    model_v = 0;
    count_up = dir;
    rst_n = 1'b1;
  endtask

  initial begin
    rst_n = 1'b0;
    count_up = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    check(count_val == 4'd0, "R1 reset state", int'(count_val), 0);
    rst_n = 1'b1;
    // R2: ascending with wrap 6 -> 0
    run_steps(1'b1, 5);
    // R3: direction change mid-sequence at value 2, descending wrap 0 -> 6
    run_steps(1'b0, 4);
    // R6: brief direction flip between step edges is ignored
    count_up = 1'b1;
    @(negedge clk); #1;
    count_up = 1'b0;
    run_steps(1'b0, 1);
    check(int'(count_val) == 0, "R6 direction pulse ignored", int'(count_val), 0);
    // R1: reset mid-run at a non-zero value
    run_steps(1'b1, 2);
    apply_reset(1'b0);
    // R3/R5: descending after reset starts at 6
    run_steps(1'b0, 5);
    check(exp_q.size() == 0, "R4 scoreboard drained", exp_q.size(), 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R4 actual=%0d expected=%0d", steps_seen, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule